// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This unit decides, for a six-stage in-order integer pipeline (fetch, decode, register read, ALU, memory, writeback), where each ALU operand of the next instruction comes from. It also decides whether that instruction may advance at all. It is fed the decoded fields of the instruction sitting in the register-read stage: its two source register numbers with their use flags, and its destination, write enable and load flag. It keeps its own record of the producers now occupying the ALU, memory and writeback stages.

On every cycle it compares the consumer's sources with those three producers. When the consumer advances into the ALU stage, it presents one registered operand-source select for each operand. Where the needed value cannot yet be bypassed, it raises a stall. The stall freezes fetch, decode and register read, and a bubble is placed into the ALU stage while older instructions move on.

A mode input turns all bypass paths off. With bypass off, consumers wait until the producer has reached writeback, because the register file's write-before-read timing hands the value over there.

Top module: `fwd_ilock_unit`

## Requirements
- R1: After reset, `stall` is low and both operand selects are 0 (register file).
- R2: Select encoding is 0 = register file, 1 = ALU stage output, 2 = memory stage output, 3 = writeback stage output. A non-load producer one instruction ahead of a consumer gives select 1 on that operand, with no stall.
- R3: A producer two instructions ahead gives select 2, and one three ahead gives select 3, both with no stall.
- R4: When several in-flight producers write the consumer's register, the nearest one is chosen: 1 beats 2, and 2 beats 3.
- R5: A consumer directly behind a load that writes one of its used sources is stalled for exactly one cycle. It then receives select 2 for that operand.
- R6: A load followed by an instruction that does not use the loaded register causes no stall.
- R7: Register 0 never matches. A producer writing register 0 causes neither a forward nor a stall.
- R8: A producer counts only when it is valid and has its write enable set. A source counts only when its use flag is set and the consumer is valid.
- R9: With `bypass_en` low, both selects are 0. A consumer is stalled while any matching producer sits in the ALU or memory stage, whether that producer is a load or not. This gives two stall cycles for a distance of one and one stall cycle for a distance of two.
- R10: The cycle after a stall, both selects are 0, since the ALU stage holds the injected bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | 1 = bypass paths enabled, 0 = wait for writeback |
| rd_valid | input | 1 | Register-read stage holds a real instruction |
| rd_src_a | input | REG_AW | First source register number |
| rd_use_a | input | 1 | First source is read |
| rd_src_b | input | REG_AW | Second source register number |
| rd_use_b | input | 1 | Second source is read |
| rd_dst | input | REG_AW | Destination register number |
| rd_wen | input | 1 | Instruction writes its destination |
| rd_load | input | 1 | Instruction is a load |
| stall | output | 1 | Hold front stages and insert a bubble into the ALU stage |
| fwd_sel_a | output | 2 | Source select for the first operand of the instruction in the ALU stage |
| fwd_sel_b | output | 2 | Source select for the second operand of the instruction in the ALU stage |

## Verification
The hardest situations to reach are several producers of one register in flight at once, and a stalled consumer re-presented while its producer moves on. The driver feeds the register-read stage back-to-back writers of the same register before a consumer, so that all three stages hold a match together. It then holds a stalled consumer's fields unchanged across the stall cycles, which lets the injected bubble and the later forward from the memory output be seen on the selects. The no-bypass runs repeat this pattern at distances one and two, with both a plain producer and a load.

// File: rtl/fwd_ilock_pkg.sv
package fwd_ilock_pkg;

    // Operand source select values presented to the ALU operand muxes
    typedef enum logic [1:0] {
        FWD_RF  = 2'd0,
        FWD_ALU = 2'd1,
        FWD_MEM = 2'd2,
        FWD_WB  = 2'd3
    } fwd_src_e;

    // Number of tracked producer stages: ALU, memory, writeback
    localparam int FWD_NSRC = 3;
    // Number of ALU operands per instruction
    localparam int FWD_NOPS = 2;

endpackage

// File: rtl/fwd_src_match.sv
// One comparator: does a tracked producer supply a given consumer source?
module fwd_src_match #(
    parameter int AW = 5
) (
    input  logic          p_valid,
    input  logic          p_wen,
    input  logic [AW-1:0] p_dst,
    input  logic [AW-1:0] c_src,
    input  logic          c_use,
    output logic          hit
);
    logic dst_nonzero;

    always_comb begin
        dst_nonzero = |p_dst;
        hit = p_valid && p_wen && dst_nonzero && c_use && (p_dst == c_src);
    end
endmodule

// File: rtl/fwd_pick.sv
// Priority pick: index 0 is the youngest producer and wins.
module fwd_pick
    import fwd_ilock_pkg::*;
#(
    parameter int NSRC = FWD_NSRC
) (
    input  logic [NSRC-1:0] hits,
    output fwd_src_e        sel
);
    always_comb begin
        sel = FWD_RF;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hits[i]) begin
                sel = fwd_src_e'(2'(i + 1));
            end
        end
    end
endmodule

// File: rtl/fwd_ilock_unit.sv
module fwd_ilock_unit
    import fwd_ilock_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass_en,
    input  logic              rd_valid,
    input  logic [REG_AW-1:0] rd_src_a,
    input  logic              rd_use_a,
    input  logic [REG_AW-1:0] rd_src_b,
    input  logic              rd_use_b,
    input  logic [REG_AW-1:0] rd_dst,
    input  logic              rd_wen,
    input  logic              rd_load,
    output logic              stall,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b
);
    localparam int NSRC = FWD_NSRC;
    localparam int NOPS = FWD_NOPS;
    localparam int ST_ALU = 0;
    localparam int ST_MEM = 1;

    typedef struct packed {
        logic              vld;
        logic              wen;
        logic              ld;
        logic [REG_AW-1:0] dst;
    } prod_t;

    typedef struct packed {
        prod_t [NSRC-1:0] stg;
        fwd_src_e         fa;
        fwd_src_e         fb;
    } state_t;

    state_t st_d, st_q;

    logic [NOPS-1:0][REG_AW-1:0] op_src;
    logic [NOPS-1:0]             op_use;
    logic [NOPS-1:0][NSRC-1:0]   op_hit;
    fwd_src_e [NOPS-1:0]         op_sel;

    assign op_src[0] = rd_src_a;
    assign op_src[1] = rd_src_b;
    assign op_use[0] = rd_use_a & rd_valid;
    assign op_use[1] = rd_use_b & rd_valid;

    // Comparator grid: every operand against every tracked producer
    for (genvar o = 0; o < NOPS; o++) begin : g_op
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            fwd_src_match #(.AW(REG_AW)) u_match (
                .p_valid (st_q.stg[s].vld),
                .p_wen   (st_q.stg[s].wen),
                .p_dst   (st_q.stg[s].dst),
                .c_src   (op_src[o]),
                .c_use   (op_use[o]),
                .hit     (op_hit[o][s])
            );
        end
        fwd_pick #(.NSRC(NSRC)) u_pick (
            .hits (op_hit[o]),
            .sel  (op_sel[o])
        );
    end

    logic hit_alu;
    logic hit_near;
    logic stall_c;

    always_comb begin
        hit_alu  = 1'b0;
        hit_near = 1'b0;
        for (int o = 0; o < NOPS; o++) begin
            hit_alu  = hit_alu  | op_hit[o][ST_ALU];
            hit_near = hit_near | op_hit[o][ST_ALU] | op_hit[o][ST_MEM];
        end
        if (bypass_en) begin
            // Load data exists only after the memory stage: one-cycle hold
            stall_c = hit_alu && st_q.stg[ST_ALU].ld;
        end else begin
            // No bypass: wait until the producer reaches writeback
            stall_c = hit_near;
        end

        st_d = st_q;
        // Older producers always advance
        for (int s = NSRC - 1; s > 0; s--) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
        if (stall_c) begin
            st_d.stg[ST_ALU] = '0;
            st_d.fa          = FWD_RF;
            st_d.fb          = FWD_RF;
        end else begin
            st_d.stg[ST_ALU].vld = rd_valid;
            st_d.stg[ST_ALU].wen = rd_wen;
            st_d.stg[ST_ALU].ld  = rd_load;
            st_d.stg[ST_ALU].dst = rd_dst;
            st_d.fa = bypass_en ? op_sel[0] : FWD_RF;
            st_d.fb = bypass_en ? op_sel[1] : FWD_RF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall     = stall_c;
    assign fwd_sel_a = st_q.fa;
    assign fwd_sel_b = st_q.fb;

endmodule

// File: rtl/fwd_ilock_chk.sv
module fwd_ilock_chk #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bypass_en,
    input logic              rd_valid,
    input logic [REG_AW-1:0] rd_src_a,
    input logic              rd_use_a,
    input logic [REG_AW-1:0] rd_src_b,
    input logic              rd_use_b,
    input logic              stall,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b
);
    // R10: the cycle after a stall the ALU stage holds a bubble
    p_bubble_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));

    // R9: with bypass off the selects stay on the register file
    p_nobyp_rf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass_en |=> (fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));

    // R5: with bypass on, a load-use stall lasts one cycle only
    p_single_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_en && $past(bypass_en) && $past(stall)) |-> !stall);

    // R9: never more than two stall cycles in a row
    p_stall_max2_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stall) && $past(stall, 2)) |-> !stall);

    // R8: an empty register-read slot never stalls
    p_idle_nostall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> !stall);

    // R7: a consumer reading only register 0 never stalls
    p_reg0_nostall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rd_use_a || rd_src_a == '0) && (!rd_use_b || rd_src_b == '0)) |-> !stall);
endmodule

bind fwd_ilock_unit fwd_ilock_chk u_chk (.*);

// File: tb/fwd_ilock_unit_tb.sv
module fwd_ilock_unit_tb;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bypass_en = 1'b1;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_src_a = '0;
    logic          rd_use_a = 1'b0;
    logic [AW-1:0] rd_src_b = '0;
    logic          rd_use_b = 1'b0;
    logic [AW-1:0] rd_dst = '0;
    logic          rd_wen = 1'b0;
    logic          rd_load = 1'b0;
    logic          stall;
    logic [1:0]    fwd_sel_a;
    logic [1:0]    fwd_sel_b;

    always #4 clk = ~clk;

    fwd_ilock_unit #(.REG_AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en),
        .rd_valid(rd_valid), .rd_src_a(rd_src_a), .rd_use_a(rd_use_a),
        .rd_src_b(rd_src_b), .rd_use_b(rd_use_b), .rd_dst(rd_dst),
        .rd_wen(rd_wen), .rd_load(rd_load),
        .stall(stall), .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
    );

    typedef struct {
        logic       st;
        logic [1:0] fa;
        logic [1:0] fb;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    // Driver: present one register-read slot per cycle, queue what must be seen
    task automatic cyc(input logic v, input logic [AW-1:0] sa, input logic ua,
                       input logic [AW-1:0] sb, input logic ub,
                       input logic [AW-1:0] d, input logic w, input logic l,
                       input logic byp, input logic est,
                       input logic [1:0] efa, input logic [1:0] efb,
                       input string req);
        exp_t e;
        @(posedge clk);
        #2;
        rd_valid = v; rd_src_a = sa; rd_use_a = ua; rd_src_b = sb;
        rd_use_b = ub; rd_dst = d; rd_wen = w; rd_load = l; bypass_en = byp;
        e.st = est; e.fa = efa; e.fb = efb; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic idle(input logic byp, input logic [1:0] efa,
                        input logic [1:0] efb, input string req);
        cyc(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, byp, 1'b0, efa, efb, req);
    endtask

    // Monitor: sample two ns before the next rising edge
    initial begin
        forever begin
            @(posedge clk);
            #6;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (stall !== e.st || fwd_sel_a !== e.fa || fwd_sel_b !== e.fb) begin
                    n_bad++;
                    $display("FAIL %s: stall/sel_a/sel_b = %0b/%0d/%0d, expected %0b/%0d/%0d",
                             e.req, stall, fwd_sel_a, fwd_sel_b, e.st, e.fa, e.fb);
                end
            end
        end
    end

    initial begin
        #40000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state, then R2/R3 distances 1, 2, 3
        cyc(1, 0,0, 0,0, 5,1,0, 1, 0,0,0, "R1");
        cyc(1, 5,1, 0,0, 6,1,0, 1, 0,0,0, "R2");
        cyc(1, 6,1, 5,1, 7,1,0, 1, 0,1,0, "R2");
        cyc(1, 5,1, 6,1, 8,1,0, 1, 0,1,2, "R3");
        idle(1, 3,2, "R3");
        idle(1, 0,0, "R3");

        // R4: three writers of register 9 in flight
        cyc(1, 0,0, 0,0, 9,1,0, 1, 0,0,0, "R4");
        cyc(1, 0,0, 0,0, 9,1,0, 1, 0,0,0, "R4");
        cyc(1, 9,1, 9,1, 9,1,0, 1, 0,0,0, "R4");
        cyc(1, 9,1, 9,1, 10,1,0, 1, 0,1,1, "R4");
        cyc(1, 9,1, 10,1, 11,1,0, 1, 0,1,1, "R4");
        idle(1, 2,1, "R4");
        idle(1, 0,0, "R4");

        // R5 load-use stall, R10 bubble, R6 load without use
        cyc(1, 0,0, 0,0, 12,1,1, 1, 0,0,0, "R5");
        cyc(1, 12,1, 0,0, 13,1,0, 1, 1,0,0, "R5");
        cyc(1, 12,1, 0,0, 13,1,0, 1, 0,0,0, "R10");
        idle(1, 2,0, "R5");
        cyc(1, 0,0, 0,0, 14,1,1, 1, 0,0,0, "R6");
        cyc(1, 15,1, 14,0, 16,1,0, 1, 0,0,0, "R6");
        cyc(1, 14,1, 0,0, 17,1,0, 1, 0,0,0, "R6");
        idle(1, 2,0, "R6");

        // R7 register 0, R8 store / invalid producers
        cyc(1, 0,0, 0,0, 0,1,0, 1, 0,0,0, "R7");
        cyc(1, 0,1, 0,1, 20,1,0, 1, 0,0,0, "R7");
        cyc(1, 0,0, 0,0, 21,0,0, 1, 0,0,0, "R8");
        cyc(1, 21,1, 0,0, 22,1,0, 1, 0,0,0, "R8");
        cyc(0, 0,0, 0,0, 23,1,1, 1, 0,0,0, "R8");
        cyc(1, 23,1, 23,1, 24,1,0, 1, 0,0,0, "R8");
        cyc(1, 0,0, 0,0, 0,1,1, 1, 0,0,0, "R7");
        cyc(1, 0,1, 0,1, 25,1,0, 1, 0,0,0, "R7");
        idle(1, 0,0, "R7");

        // R9: bypass disabled, distance 1, distance 2, and a load
        cyc(1, 0,0, 0,0, 26,1,0, 0, 0,0,0, "R9");
        cyc(1, 26,1, 0,0, 27,1,0, 0, 1,0,0, "R9");
        cyc(1, 26,1, 0,0, 27,1,0, 0, 1,0,0, "R9");
        cyc(1, 26,1, 0,0, 27,1,0, 0, 0,0,0, "R9");
        idle(0, 0,0, "R9");
        cyc(1, 0,0, 0,0, 28,1,0, 0, 0,0,0, "R9");
        idle(0, 0,0, "R9");
        cyc(1, 0,0, 28,1, 29,1,0, 0, 1,0,0, "R9");
        cyc(1, 0,0, 28,1, 29,1,0, 0, 0,0,0, "R9");
        idle(0, 0,0, "R9");
        cyc(1, 0,0, 0,0, 30,1,1, 0, 0,0,0, "R9");
        cyc(1, 30,1, 0,0, 31,1,0, 0, 1,0,0, "R9");
        cyc(1, 30,1, 0,0, 31,1,0, 0, 1,0,0, "R9");
        cyc(1, 30,1, 0,0, 31,1,0, 0, 0,0,0, "R9");
        idle(0, 0,0, "R9");

        repeat (3) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule